// File: doc/BRIEF.md
# LCD Column Driver Data Path

This block is the digital core of a column driver for a passive LCD panel. It takes one row of display data over a 4-bit or 8-bit parallel bus, one group per falling edge of a shift strobe. It places each group into a row-wide data latch, filling from one end of the row or the other. A falling edge on a row-load strobe copies the whole data latch into a line latch. Each column's line-latch bit, a frame-polarity input and a blanking input then choose a 2-bit drive-level code for that column. The analog stage outside the block turns each code into a bias voltage.

All logic runs on one system clock. The shift strobe, the row-load strobe and all the other inputs are sampled on the rising edge of that clock. A falling edge is counted on the clock edge at which a strobe is seen low after it was seen high on the edge before. Two state machines carry the control:

- **Fill controller**
  - `FILL_ACTIVE`: groups are accepted. It moves to `FILL_DONE` on the write that brings the row pointer to the last column.
  - `FILL_DONE`: shift edges are ignored. It returns to `FILL_ACTIVE` on a row-load edge, which also sets the pointer back to the starting end.
- **Drive controller**
  - `DRV_DARK`: entered from any state while blanking is asserted. It moves to `DRV_HOLD` when blanking is released.
  - `DRV_HOLD`: drives the non-select level. It moves to `DRV_SHOW` on the next row-load edge.
  - `DRV_SHOW`: drives the levels decoded from the line latch.
  - Reset enters `DRV_HOLD`.

Top module: `lcd_col_drv`

## Requirements
- R1: With `wide_mode`=1, each shift edge stores all eight bits of `din` into the next eight columns of the fill order. Bit k of `din` goes to the column k places after the pointer.
- R2: With `wide_mode`=0, each shift edge stores `din[3:0]` into the next four columns. `din[7:4]` has no effect on any column.
- R3: With `fill_up`=1, the fill order runs from column 1 toward column 160, so `din[0]` lands in the lowest column of the group. With `fill_up`=0, the order runs from column 160 toward column 1, so `din[0]` lands in the highest column of the group. Column c drives `seg_lvl[2c-1:2c-2]`.
- R4: A row-load edge copies the whole data latch into the line latch. The new levels appear at the outputs on that same clock edge. The row-load edge also returns the pointer to the starting end.
- R5: Once 160 bits of a row have been stored, further shift edges change nothing until the next row-load edge.
- R6: Level codes are 00 for ground, 01 for the low-middle bias, 10 for the high-middle bias and 11 for the top bias. With `frame_pol`=1, a set line bit gives 11 and a clear line bit gives 10. With `frame_pol`=0, a set line bit gives 00 and a clear line bit gives 01.
- R7: While `blank_n`=0, every output is 00 from the next clock edge on, and the line latch is held clear.
- R8: While `blank_n`=0, shift edges still store data into the data latch. A row-load edge in that time moves the pointer back to the start.
- R9: After `blank_n` returns to 1, every output shows the non-select level: 10 when `frame_pol`=1 and 01 when `frame_pol`=0. This holds until the next row-load edge, which loads the line latch and resumes normal output.
- R10: After reset, the pointer is at the starting end, both latches are clear and every output shows the non-select level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_clk | input | 1 | Data shift strobe; data is taken on its falling edge |
| row_load | input | 1 | Row-load strobe; the line latch loads on its falling edge |
| wide_mode | input | 1 | 1: 8-bit groups; 0: 4-bit groups |
| fill_up | input | 1 | 1: fill from column 1 upward; 0: fill from column 160 downward |
| blank_n | input | 1 | Active-low blanking |
| frame_pol | input | 1 | Frame polarity used by the level decode |
| din | input | 8 | Parallel display data |
| seg_lvl | output | 320 | 2-bit level code per column; column 1 is in the lowest bits |

## Verification
The assertions assume that every strobe level lasts at least one system clock, so that each falling edge is seen exactly once. They also assume that reset is asserted before the first strobe. The stimulus drives every input on the falling clock edge and holds each strobe level for at least one full period, which keeps it inside these assumptions. The random sequence mixes shift edges, row loads, blanking toggles, polarity flips, width changes and direction changes, including changes in the middle of a row. Directed runs cover a full row, a row overrun and the blanking release.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

    typedef enum logic [1:0] {
        LVL_GND  = 2'b00,
        LVL_LMID = 2'b01,
        LVL_HMID = 2'b10,
        LVL_TOP  = 2'b11
    } lvl_e;

    typedef enum logic {
        FILL_ACTIVE = 1'b0,
        FILL_DONE   = 1'b1
    } fill_st_e;

    typedef enum logic [1:0] {
        DRV_DARK = 2'b00,
        DRV_HOLD = 2'b01,
        DRV_SHOW = 2'b10
    } drv_st_e;

    function automatic lvl_e lvl_of(input logic bit_on, input logic pol);
        lvl_e r;
        if (pol) r = bit_on ? LVL_TOP : LVL_HMID;
        else     r = bit_on ? LVL_GND : LVL_LMID;
        return r;
    endfunction

endpackage

// File: rtl/lcd_fall_det.sv
module lcd_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= sig;
    end

    assign fall = seen_q & ~sig;
endmodule

// File: rtl/lcd_fill_ctrl.sv
module lcd_fill_ctrl
    import lcd_col_pkg::*;
#(
    parameter int NCOL = 160,
    parameter int BUSW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_fall,
    input  logic            load_fall,
    input  logic            wide_mode,
    input  logic            fill_up,
    input  logic [BUSW-1:0] din,
    output logic [NCOL-1:0] data_q
);
    localparam int NARROW = BUSW / 2;
    localparam int PW     = $clog2(NCOL + 1);
    localparam int IW     = $clog2(BUSW);
    localparam int SW     = PW + 2;

    fill_st_e        st_q, st_d;
    logic [PW-1:0]   pos_q, pos_d;
    logic signed [SW-1:0] grp_w;
    logic signed [SW-1:0] pos_s;
    logic signed [SW-1:0] nxt_s;
    logic            wr_en;
    logic [NCOL-1:0] hit_v;
    logic [NCOL-1:0] bit_v;

    assign grp_w = wide_mode ? SW'(BUSW) : SW'(NARROW);
    assign pos_s = $signed({2'b00, pos_q});
    assign nxt_s = pos_s + grp_w;
    assign wr_en = shift_fall & ~load_fall & (st_q == FILL_ACTIVE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FILL_ACTIVE;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        unique case (st_q)
            FILL_ACTIVE: begin
                if (load_fall) begin
                    pos_d = '0;
                end else if (wr_en) begin
                    if (nxt_s >= SW'(NCOL)) begin
                        pos_d = PW'(NCOL);
                        st_d  = FILL_DONE;
                    end else begin
                        pos_d = nxt_s[PW-1:0];
                    end
                end
            end
            FILL_DONE: begin
                if (load_fall) begin
                    pos_d = '0;
                    st_d  = FILL_ACTIVE;
                end
            end
            default: begin
                st_d  = FILL_ACTIVE;
                pos_d = '0;
            end
        endcase
    end

    // per-column write decode
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam logic [PW-1:0] UPV = PW'(c);
        localparam logic [PW-1:0] DNV = PW'(NCOL - 1 - c);
        logic signed [SW-1:0] off_c;
        assign off_c    = $signed({2'b00, (fill_up ? UPV : DNV)}) - pos_s;
        assign hit_v[c] = wr_en && (off_c >= 0) && (off_c < grp_w);
        assign bit_v[c] = din[off_c[IW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= (data_q & ~hit_v) | (bit_v & hit_v);
    end

    p_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= PW'(NCOL));
    p_done_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FILL_DONE && !load_fall) |=> ($stable(data_q) && $stable(pos_q)));
    p_load_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> (pos_q == '0 && st_q == FILL_ACTIVE));
    p_group_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(hit_v) <= BUSW));
endmodule

// File: rtl/lcd_drive_ctrl.sv
module lcd_drive_ctrl
    import lcd_col_pkg::*;
#(
    parameter int NCOL = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_fall,
    input  logic              blank_n,
    input  logic              frame_pol,
    input  logic [NCOL-1:0]   data_q,
    output logic [2*NCOL-1:0] lvl_o
);
    drv_st_e         st_q, st_d;
    logic [NCOL-1:0] line_q, line_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DRV_HOLD;
            line_q <= '0;
        end else begin
            st_q   <= st_d;
            line_q <= line_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        line_d = line_q;
        if (!blank_n) begin
            st_d   = DRV_DARK;
            line_d = '0;
        end else begin
            unique case (st_q)
                DRV_DARK: st_d = DRV_HOLD;
                DRV_HOLD: begin
                    if (load_fall) begin
                        line_d = data_q;
                        st_d   = DRV_SHOW;
                    end
                end
                DRV_SHOW: begin
                    if (load_fall) line_d = data_q;
                end
                default: st_d = DRV_HOLD;
            endcase
        end
    end

    // outputs
    for (genvar c = 0; c < NCOL; c++) begin : g_out
        always_comb begin
            unique case (st_q)
                DRV_DARK: lvl_o[2*c+1:2*c] = LVL_GND;
                DRV_HOLD: lvl_o[2*c+1:2*c] = lvl_of(1'b0, frame_pol);
                DRV_SHOW: lvl_o[2*c+1:2*c] = lvl_of(line_q[c], frame_pol);
                default:  lvl_o[2*c+1:2*c] = LVL_GND;
            endcase
        end
    end

    p_dark_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> (line_q == '0 && lvl_o == '0));
    p_hold_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DRV_HOLD) |-> (line_q == '0));
    p_show_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && load_fall && st_q != DRV_DARK) |=> (line_q == $past(data_q)));
    p_release_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DRV_DARK && blank_n) |=> (st_q == DRV_HOLD || st_q == DRV_DARK));
endmodule

// File: rtl/lcd_col_drv.sv
module lcd_col_drv
    import lcd_col_pkg::*;
#(
    parameter int NCOL = 160,
    parameter int BUSW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk,
    input  logic              row_load,
    input  logic              wide_mode,
    input  logic              fill_up,
    input  logic              blank_n,
    input  logic              frame_pol,
    input  logic [BUSW-1:0]   din,
    output logic [2*NCOL-1:0] seg_lvl
);
    logic            shift_fall;
    logic            load_fall;
    logic [NCOL-1:0] data_q;

    lcd_fall_det u_shift_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (shift_clk),
        .fall (shift_fall)
    );

    lcd_fall_det u_load_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (row_load),
        .fall (load_fall)
    );

    lcd_fill_ctrl #(.NCOL(NCOL), .BUSW(BUSW)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_fall(shift_fall),
        .load_fall (load_fall),
        .wide_mode (wide_mode),
        .fill_up   (fill_up),
        .din       (din),
        .data_q    (data_q)
    );

    lcd_drive_ctrl #(.NCOL(NCOL)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_fall(load_fall),
        .blank_n  (blank_n),
        .frame_pol(frame_pol),
        .data_q   (data_q),
        .lvl_o    (seg_lvl)
    );

    p_single_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_fall |=> !shift_fall);
    p_row_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> !load_fall);
endmodule

// File: tb/tb_lcd_col_drv.sv
module tb_lcd_col_drv;
    localparam int NCOL = 160;
    localparam int BUSW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              shift_clk = 1'b0;
    logic              row_load = 1'b0;
    logic              wide_mode = 1'b1;
    logic              fill_up = 1'b1;
    logic              blank_n = 1'b1;
    logic              frame_pol = 1'b1;
    logic [BUSW-1:0]   din = '0;
    logic [2*NCOL-1:0] seg_lvl;

    int n_cmp = 0;
    int n_bad = 0;

    logic [NCOL-1:0] m_data;
    logic [NCOL-1:0] m_line;
    int              m_pos;
    int              m_mode; // 0 dark, 1 hold, 2 show

    always #2 clk = ~clk;

    lcd_col_drv #(.NCOL(NCOL), .BUSW(BUSW)) dut (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .row_load(row_load),
        .wide_mode(wide_mode), .fill_up(fill_up), .blank_n(blank_n),
        .frame_pol(frame_pol), .din(din), .seg_lvl(seg_lvl)
    );

    function automatic logic [1:0] exp_lvl(input int c);
        logic [1:0] r;
        if (m_mode == 0)      r = 2'b00;
        else if (m_mode == 1) r = frame_pol ? 2'b10 : 2'b01;
        else if (frame_pol)   r = m_line[c] ? 2'b11 : 2'b10;
        else                  r = m_line[c] ? 2'b00 : 2'b01;
        return r;
    endfunction

    task automatic check(input string req);
        int bad_c = -1;
        n_cmp++;
        for (int c = 0; c < NCOL; c++)
            if (bad_c < 0 && seg_lvl[2*c +: 2] !== exp_lvl(c)) bad_c = c;
        if (bad_c >= 0) begin
            n_bad++;
            $display("FAIL %s: column %0d level %b expected %b", req, bad_c + 1,
                     seg_lvl[2*bad_c +: 2], exp_lvl(bad_c));
        end
    endtask

    task automatic shift(input logic [BUSW-1:0] d);
        int w;
        @(negedge clk) shift_clk = 1'b1;
        @(negedge clk) begin shift_clk = 1'b0; din = d; end
        w = wide_mode ? BUSW : BUSW / 2;
        if (m_pos < NCOL) begin
            for (int k = 0; k < w; k++) begin
                int p = m_pos + k;
                if (p < NCOL) m_data[fill_up ? p : NCOL - 1 - p] = d[k];
            end
            m_pos = m_pos + w;
        end
        @(negedge clk);
    endtask

    task automatic load_row();
        @(negedge clk) row_load = 1'b1;
        @(negedge clk) row_load = 1'b0;
        if (blank_n && m_mode != 0) begin
            m_line = m_data;
            m_mode = 2;
        end
        m_pos = 0;
        @(negedge clk);
    endtask

    task automatic set_blank(input logic v);
        @(negedge clk) blank_n = v;
        if (!v) begin m_mode = 0; m_line = '0; end
        else if (m_mode == 0) m_mode = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        m_data = '0; m_line = '0; m_pos = 0; m_mode = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset non-select pol1");
        frame_pol = 1'b0; @(negedge clk);
        check("R10 reset non-select pol0");
        load_row();
        check("R10 empty row after reset");
        frame_pol = 1'b1;

        // R1 R3: full row in 8-bit mode, filling upward
        wide_mode = 1'b1; fill_up = 1'b1;
        for (int i = 0; i < NCOL / 8; i++) shift(8'(i * 37 + 1));
        load_row();
        check("R1 R3 R4 wide upward row");
        // R5: overrun after a full row is ignored
        for (int i = 0; i < NCOL / 8; i++) shift(8'(i * 11 + 5));
        shift(8'hFF); shift(8'hA5);
        load_row();
        check("R5 overrun ignored");

        // R2 R3: 4-bit mode downward with upper nibble noise
        wide_mode = 1'b0; fill_up = 1'b0;
        for (int i = 0; i < NCOL / 4; i++) shift({4'hF ^ 4'(i), 4'(i * 3)});
        load_row();
        check("R2 R3 narrow downward row");
        frame_pol = 1'b0; @(negedge clk);
        check("R6 polarity low encode");
        frame_pol = 1'b1; @(negedge clk);
        check("R6 polarity high encode");

        // R7 R8 R9: blanking
        set_blank(1'b0);
        check("R7 blank forces ground");
        wide_mode = 1'b1; fill_up = 1'b1;
        for (int i = 0; i < 6; i++) shift(8'hC3 ^ 8'(i));
        load_row();
        check("R7 row load while blanked");
        for (int i = 0; i < 4; i++) shift(8'h5A + 8'(i));
        set_blank(1'b1);
        check("R9 non-select after release");
        frame_pol = 1'b0; @(negedge clk);
        check("R9 non-select pol0");
        load_row();
        check("R8 data kept during blank shown");

        // random mix
        for (int it = 0; it < 1500; it++) begin
            int op = int'($urandom_range(0, 99));
            if (op < 70)      shift(8'($urandom));
            else if (op < 80) load_row();
            else if (op < 84) set_blank(~blank_n);
            else if (op < 90) begin frame_pol = $urandom_range(0, 1) != 0; @(negedge clk); end
            else if (op < 95) wide_mode = $urandom_range(0, 1) != 0;
            else              fill_up = $urandom_range(0, 1) != 0;
            if (op >= 70) check("R4 R6 R7 R9 random step");
            else if (it % 8 == 0) check("R1 R2 R3 R5 random shift");
        end
        if (!blank_n) set_blank(1'b1);
        load_row();
        check("R8 R4 final row");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule